// File: doc/BRIEF.md
# Remote Transmitter Kill and Revive Gate

This block sits beside a receive path and watches the destination address of every incoming frame. It folds the six address bytes into a CRC-32 and takes six bits of the result as a bin number from 0 to 63. Two of those bins act as commands from the network. When the feature is armed, a good multicast frame in the kill bin turns the local transmitter off. A good multicast frame in the revive bin turns it back on. No other frame changes the transmitter state.

The receive side supplies a start strobe for each frame and then the address bytes with a valid qualifier. Bytes after the sixth are ignored. When the frame check later passes, the receive side pulses a good strobe, and only that pulse can change the state. Software controls a single arm bit. Dropping the arm bit re-enables the transmitter at once and keeps it enabled for as long as the bit stays low.

Top module: `remote_tx_gate`

## Requirements
- R1: After reset `tx_en_o` is 1.
- R2: While `arm_i` is 0, `tx_en_o` is 1 from the cycle after `arm_i` goes low, whatever frames arrive.
- R3: With `arm_i` at 1, a good multicast frame whose bin is 62 drives `tx_en_o` to 0 in the cycle after the `frame_good_i` pulse.
- R4: With `arm_i` at 1, a good multicast frame whose bin is 63 drives `tx_en_o` to 1 in the cycle after the `frame_good_i` pulse.
- R5: A good multicast frame whose bin is neither 62 nor 63 leaves `tx_en_o` unchanged.
- R6: A frame is multicast only when bit 0 of address byte 0 is 1. A frame with that bit at 0 has no effect, whatever its bin.
- R7: A frame changes the state only on a `frame_good_i` pulse, and only if all six address bytes were captured. A frame with no good pulse, or with fewer than six bytes, has no effect.
- R8: The bin is computed as follows. The register starts at all ones. It is a CRC-32 with polynomial 0x04C11DB7, fed address byte 0 first and bit 0 of each byte first, with no final inversion. The bin is register bits 31 down to 26, with bit 31 as the bin MSB.
- R9: A bin-62 frame that arrives while the transmitter is already disabled keeps `tx_en_o` at 0 in every cycle.
- R10: `sof_i` restarts address capture. Bytes after the sixth are ignored. If `byte_vld_i` is high in the same cycle as `sof_i`, that byte is byte 0.
- R11: Clearing `arm_i` while the transmitter is disabled re-enables it. Setting `arm_i` again afterwards leaves it enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arms the remote kill and revive feature |
| sof_i | input | 1 | Frame start strobe; restarts address capture |
| byte_vld_i | input | 1 | Qualifies `byte_i` |
| byte_i | input | 8 | Destination address byte stream |
| frame_good_i | input | 1 | One-cycle pulse when the frame check passes |
| tx_en_o | output | 1 | Transmitter enable level |

## Verification
A wrong hash or a wrong byte count would show up as the wrong reaction to a frame. A known bin-62 frame would leave the transmitter running, or a frame in another bin would stop it. In either case `tx_en_o` is wrong in the cycle right after the good pulse. A stale multicast flag, or a capture that does not restart on `sof_i`, would let a unicast frame, a truncated frame or a leftover address act on the state. That error also shows one cycle after the good pulse. A disable bit that does not clear when the feature is disarmed would keep `tx_en_o` low one cycle after `arm_i` falls.

// File: rtl/remote_tx_gate.sv
module remote_tx_gate #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int KILL_BIN   = 62,
  parameter int REVIVE_BIN = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_i,
  input  logic       sof_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       frame_good_i,
  output logic       tx_en_o
);

  localparam int          CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [31:0] POLY  = 32'h04C11DB7;
  localparam logic [CNT_W-1:0]     FULL   = CNT_W'(ADDR_BYTES);
  localparam logic [HASH_BITS-1:0] KILL   = HASH_BITS'(KILL_BIN);
  localparam logic [HASH_BITS-1:0] REVIVE = HASH_BITS'(REVIVE_BIN);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  logic [31:0]          crc_q, crc_base, crc_d;
  logic [CNT_W-1:0]     cnt_q, cnt_base, cnt_d;
  logic                 mcast_q, mcast_d;
  logic                 killed_q, killed_d;
  logic                 take, hit;
  logic [HASH_BITS-1:0] bin;

  assign crc_base = sof_i ? 32'hFFFF_FFFF : crc_q;
  assign cnt_base = sof_i ? '0 : cnt_q;
  assign take     = byte_vld_i && (cnt_base < FULL);
  assign crc_d    = take ? crc_step(crc_base, byte_i) : crc_base;
  assign cnt_d    = take ? cnt_base + 1'b1 : cnt_base;
  assign mcast_d  = (take && cnt_base == '0) ? byte_i[0] : (sof_i ? 1'b0 : mcast_q);

  assign bin = crc_q[31 -: HASH_BITS];
  assign hit = frame_good_i && arm_i && mcast_q && (cnt_q == FULL);

  always_comb begin
    killed_d = killed_q;
    if (!arm_i)                    killed_d = 1'b0;
    else if (hit && bin == KILL)   killed_d = 1'b1;
    else if (hit && bin == REVIVE) killed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q    <= 32'hFFFF_FFFF;
      cnt_q    <= '0;
      mcast_q  <= 1'b0;
      killed_q <= 1'b0;
    end else begin
      crc_q    <= crc_d;
      cnt_q    <= cnt_d;
      mcast_q  <= mcast_d;
      killed_q <= killed_d;
    end
  end

  assign tx_en_o = ~killed_q;

  p_reset_en_r1: assert property (@(posedge clk) $past(!rst_n) |-> tx_en_o);

  p_disarm_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> tx_en_o);

  p_fall_needs_good_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en_o) |-> $past(frame_good_i && arm_i && mcast_q));

  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> $past(frame_good_i || !arm_i));

  p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

  p_short_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && cnt_q != FULL) |=> $stable(tx_en_o));

endmodule

// File: tb/tb_remote_tx_gate.sv
`timescale 1ns/1ps
module tb_remote_tx_gate;
  logic clk = 0, rst_n = 0, arm = 0, sof = 0, bv = 0, good = 0;
  logic [7:0] bd = 0;
  logic tx_en;
  int checks = 0, errors = 0;
  bit done = 0;
  bit    q_exp[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  remote_tx_gate dut (.clk(clk), .rst_n(rst_n), .arm_i(arm), .sof_i(sof),
    .byte_vld_i(bv), .byte_i(bd), .frame_good_i(good), .tx_en_o(tx_en));

  function automatic logic [5:0] ref_bin(input logic [47:0] a);
    logic [31:0] r = 32'hFFFF_FFFF;
    logic [5:0] b;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = r[0] ^ a[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    for (int j = 0; j < 6; j++) b[5-j] = r[j];
    return b;
  endfunction

  function automatic logic [47:0] find_addr(input bit mc, input int want, input int avoid_lo);
    for (int k = avoid_lo; k < 65536; k++) begin
      logic [47:0] a;
      a = {k[7:0], k[15:8], 8'h00, 8'h5E, 8'h00, (mc ? 8'h01 : 8'h02)};
      if (want >= 0 && ref_bin(a) == want[5:0]) return a;
      if (want < 0 && ref_bin(a) < 6'd62) return a;
    end
    return '0;
  endfunction

  task automatic expect_now(input bit e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      bit e; string t;
      e = q_exp.pop_front(); t = q_tag.pop_front();
      checks++;
      if (tx_en !== e) begin
        errors++;
        $display("FAIL %s tx_en=%b expected=%b", t, tx_en, e);
      end
    end
  end

  bit glitch_watch = 0;
  always @(negedge clk) if (glitch_watch && tx_en !== 1'b0) begin
    errors++;
    $display("FAIL R9 tx_en=%b expected=0 during repeat kill frame", tx_en);
  end

  task automatic send_frame(input logic [47:0] a, input int nb, input bit g, input bit pre_junk);
    if (pre_junk) begin
      @(posedge clk) #1; sof = 1; bv = 1; bd = 8'h33;
      for (int i = 0; i < 2; i++) begin @(posedge clk) #1; sof = 0; bd = 8'h77; end
      @(posedge clk) #1; bv = 0;
    end
    for (int i = 0; i < nb; i++) begin
      @(posedge clk) #1;
      sof = (i == 0); bv = 1;
      bd = (i < 6) ? a[8*i +: 8] : 8'hA5;
    end
    @(posedge clk) #1; sof = 0; bv = 0;
    @(posedge clk) #1; good = g;
    @(posedge clk) #1; good = 0;
  endtask

  logic [47:0] a62, a63, aoth, auni62, aoth2;

  initial begin
    a62    = find_addr(1, 62, 0);
    a63    = find_addr(1, 63, 0);
    aoth   = find_addr(1, -1, 0);
    aoth2  = find_addr(1, -1, 300);
    auni62 = find_addr(0, 62, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    expect_now(1, "R1 reset enable");
    arm = 1;
    send_frame(a62, 6, 1, 0);  expect_now(0, "R3 R8 kill bin");
    glitch_watch = 1;
    send_frame(a62, 6, 1, 0);  expect_now(0, "R9 repeat kill");
    glitch_watch = 0;
    send_frame(aoth, 6, 1, 0); expect_now(0, "R5 other bin while disabled");
    send_frame(a63, 6, 1, 0);  expect_now(1, "R4 R8 revive bin");
    send_frame(aoth2, 6, 1, 0); expect_now(1, "R5 other bin while enabled");
    send_frame(auni62, 6, 1, 0); expect_now(1, "R6 unicast bin 62");
    send_frame(a62, 6, 0, 0);  expect_now(1, "R7 no good pulse");
    send_frame(a62, 5, 1, 0);  expect_now(1, "R7 short address");
    send_frame(a62, 9, 1, 0);  expect_now(0, "R10 trailing bytes ignored");
    send_frame(a63, 6, 1, 1);  expect_now(1, "R10 sof restarts capture");
    send_frame(a62, 6, 1, 0);  expect_now(0, "R3 kill before disarm");
    @(posedge clk) #1 arm = 0;
    @(posedge clk) #1;         expect_now(1, "R11 R2 disarm re-enables");
    send_frame(a62, 6, 1, 0);  expect_now(1, "R2 kill ignored while disarmed");
    @(posedge clk) #1 arm = 1;
    @(posedge clk) #1;         expect_now(1, "R11 re-arm stays enabled");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog tx_en=%b expected=finish", tx_en);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule